// File: doc/BRIEF.md
# Arbitration-Loss Retransmit Controller

This block sits beside a serial frame transmitter and decides what happens when one of its frames loses bus arbitration. Software starts a transmission with a one-cycle start command. If the transmitter reports that arbitration was lost, the block waits for two things in turn. First the frame that won arbitration must finish. Then the inter-frame space must elapse. Only then does it issue a one-cycle retransmit request. It issues that request on the first clock it may, with no extra delay.

A 2-bit retry limit sets how many automatic attempts are made per start command. With a limit of zero, the block never retransmits by itself. Instead it raises a sticky arbitration-lost flag and hands recovery to software. Software then clears the flag with a write-one-to-clear pulse, or sends a new start command. The same flag is raised when a loss occurs after the retry budget is already used up. Bit-level arbitration detection, the frame encoder and the inter-frame-space timer are outside this block and reach it as strobes.

Top module: `arb_retry_ctrl`

## Requirements
- R1: After synchronous reset, `retx_req` and `arb_lost_flag` are 0 and the block is idle: an `arb_lost` strobe in idle neither sets the flag nor leads to a retransmit.
- R2: With `retry_limit` = 0, an `arb_lost` strobe during a transmission sets `arb_lost_flag` in the cycle after the strobe is sampled.
- R3: After a retried arbitration loss, a `ifs_done` strobe that arrives before `winner_end` is ignored. The retransmit needs `winner_end` first and then a later `ifs_done`.
- R4: `retx_req` goes high in the cycle right after the clock edge that samples `ifs_done` in the waiting-for-space state. It stays high for exactly one cycle.
- R5: With `retry_limit` = N (1 to 3), one start command yields exactly N retransmit requests across N losses. Loss number N+1 sets `arb_lost_flag` and produces no retransmit.
- R6: `arb_lost_flag` stays set until a `flag_clr` pulse clears it. If a setting loss and `flag_clr` occur in the same cycle, the flag is set.
- R7: `start_cmd` clears `arb_lost_flag` and the retry count and begins a fresh transmission with the full retry budget. It takes priority over every other input.
- R8: A `tx_done` strobe during a transmission returns the block to idle, so a later `arb_lost` has no effect.
- R9: A `start_cmd` while a retry is pending cancels that retry: a following `winner_end`/`ifs_done` produces no `retx_req`.
- R10: After a zero-limit or budget-exhausted loss, no retransmit is issued for any `winner_end`/`ifs_done` until a new `start_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retry_limit | input | 2 | Number of automatic retries per start (0 = none) |
| start_cmd | input | 1 | Software start pulse for a fresh transmission |
| arb_lost | input | 1 | Transmitter strobe: arbitration lost |
| winner_end | input | 1 | Strobe: the winning frame has ended |
| ifs_done | input | 1 | Strobe: inter-frame space has elapsed |
| tx_done | input | 1 | Strobe: own transmission completed successfully |
| flag_clr | input | 1 | Write-one-to-clear pulse for the status flag |
| retx_req | output | 1 | One-cycle retransmit request to the transmitter |
| arb_lost_flag | output | 1 | Sticky arbitration-lost status for software |

## Verification
Both outputs come from registers. So each result is due exactly one cycle after the edge that samples its cause. `retx_req` is due after the `ifs_done` edge, and the flag changes after the `arb_lost`, `flag_clr` or `start_cmd` edge. The bench drives every strobe for one cycle starting at a falling edge. It samples at the next falling edge, which is the first point at which the result is due, and samples once more a cycle later to confirm that the retransmit pulse has already gone. A negative-edge monitor counts all retransmit pulses, so a late or duplicate pulse also shows up in the per-scenario totals.

// File: rtl/arb_retry_pkg.sv
package arb_retry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_TX       = 3'd1,
    ST_WAIT_WIN = 3'd2,
    ST_WAIT_IFS = 3'd3,
    ST_RETRY    = 3'd4
  } rt_state_e;
endpackage

// File: rtl/arb_retry_cnt.sv
module arb_retry_cnt #(
  parameter int LIMIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc,
  input  logic [LIMIT_W-1:0] limit,
  output logic [LIMIT_W-1:0] count,
  output logic               at_limit
);
  localparam logic [LIMIT_W-1:0] CNT_MAX = {LIMIT_W{1'b1}};

  logic [LIMIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count    = cnt_q;
  assign at_limit = (cnt_q >= limit);
endmodule

// File: rtl/arb_retry_flag.sv
module arb_retry_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic w1c,
  input  logic restart,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set) begin
      flag_q <= 1'b1;
    end else if (w1c || restart) begin
      flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/arb_retry_fsm.sv
module arb_retry_fsm
  import arb_retry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_cmd,
  input  logic arb_lost,
  input  logic winner_end,
  input  logic ifs_done,
  input  logic tx_done,
  input  logic at_limit,
  output logic cnt_inc,
  output logic cnt_clr,
  output logic flag_set,
  output logic retx_req
);
  rt_state_e st_q, st_d;
  logic      retx_q;

  always_comb begin
    st_d     = st_q;
    cnt_inc  = 1'b0;
    cnt_clr  = 1'b0;
    flag_set = 1'b0;
    if (start_cmd) begin
      st_d    = ST_TX;
      cnt_clr = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_TX: begin
          if (tx_done) begin
            st_d    = ST_IDLE;
            cnt_clr = 1'b1;
          end else if (arb_lost) begin
            if (at_limit) begin
              flag_set = 1'b1;
              st_d     = ST_IDLE;
            end else begin
              cnt_inc = 1'b1;
              st_d    = ST_WAIT_WIN;
            end
          end
        end
        ST_WAIT_WIN: if (winner_end) st_d = ST_WAIT_IFS;
        ST_WAIT_IFS: if (ifs_done) st_d = ST_RETRY;
        ST_RETRY:    st_d = ST_TX;
        default:     st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      retx_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      retx_q <= (st_d == ST_RETRY);
    end
  end

  assign retx_req = retx_q;
endmodule

// File: rtl/arb_retry_ctrl.sv
module arb_retry_ctrl #(
  parameter int LIMIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LIMIT_W-1:0] retry_limit,
  input  logic               start_cmd,
  input  logic               arb_lost,
  input  logic               winner_end,
  input  logic               ifs_done,
  input  logic               tx_done,
  input  logic               flag_clr,
  output logic               retx_req,
  output logic               arb_lost_flag
);
  logic               cnt_inc;
  logic               cnt_clr;
  logic               flag_set;
  logic               at_limit;
  logic [LIMIT_W-1:0] retry_cnt;

  arb_retry_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_cmd  (start_cmd),
    .arb_lost   (arb_lost),
    .winner_end (winner_end),
    .ifs_done   (ifs_done),
    .tx_done    (tx_done),
    .at_limit   (at_limit),
    .cnt_inc    (cnt_inc),
    .cnt_clr    (cnt_clr),
    .flag_set   (flag_set),
    .retx_req   (retx_req)
  );

  arb_retry_cnt #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .limit    (retry_limit),
    .count    (retry_cnt),
    .at_limit (at_limit)
  );

  arb_retry_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set     (flag_set),
    .w1c     (flag_clr),
    .restart (start_cmd),
    .flag    (arb_lost_flag)
  );
endmodule

// File: rtl/arb_retry_chk.sv
module arb_retry_chk #(
  parameter int LIMIT_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               arb_lost,
  input logic               ifs_done,
  input logic               flag_clr,
  input logic               start_cmd,
  input logic               retx_req,
  input logic               arb_lost_flag,
  input logic [LIMIT_W-1:0] retry_cnt
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    retx_req |=> !retx_req); // R4

  AST_REQ_AFTER_IFS: assert property (@(posedge clk) disable iff (rst)
    retx_req |-> $past(ifs_done)); // R3

  AST_REQ_HAS_BUDGET: assert property (@(posedge clk) disable iff (rst)
    retx_req |-> (retry_cnt != '0)); // R5

  AST_FLAG_SET_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost_flag) |-> $past(arb_lost)); // R2

  AST_FLAG_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(arb_lost_flag) |-> $past(flag_clr || start_cmd)); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> (!arb_lost_flag && !retx_req)); // R7
endmodule

bind arb_retry_ctrl arb_retry_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .arb_lost      (arb_lost),
  .ifs_done      (ifs_done),
  .flag_clr      (flag_clr),
  .start_cmd     (start_cmd),
  .retx_req      (retx_req),
  .arb_lost_flag (arb_lost_flag),
  .retry_cnt     (retry_cnt)
);

// File: tb/sim_arb_retry_ctrl.sv
module sim_arb_retry_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] retry_limit = 2'd0;
  logic       start_cmd = 0, arb_lost = 0, winner_end = 0;
  logic       ifs_done = 0, tx_done = 0, flag_clr = 0;
  logic       retx_req, arb_lost_flag;

  int checks = 0;
  int errors = 0;
  int retx_seen = 0;
  bit done = 0;

  localparam logic [5:0] M_START = 6'b000001;
  localparam logic [5:0] M_ARB   = 6'b000010;
  localparam logic [5:0] M_WIN   = 6'b000100;
  localparam logic [5:0] M_IFS   = 6'b001000;
  localparam logic [5:0] M_DONE  = 6'b010000;
  localparam logic [5:0] M_CLR   = 6'b100000;

  always #5 clk = ~clk;

  arb_retry_ctrl u0 (
    .clk(clk), .rst(rst), .retry_limit(retry_limit), .start_cmd(start_cmd),
    .arb_lost(arb_lost), .winner_end(winner_end), .ifs_done(ifs_done),
    .tx_done(tx_done), .flag_clr(flag_clr), .retx_req(retx_req),
    .arb_lost_flag(arb_lost_flag)
  );

  always @(negedge clk) if (!rst && retx_req) retx_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive strobes for one cycle from a falling edge; returns at the next
  // falling edge, where registered results of that edge are visible
  task automatic drive(input logic [5:0] m);
    {flag_clr, tx_done, ifs_done, winner_end, arb_lost, start_cmd} = m;
    @(negedge clk);
    {flag_clr, tx_done, ifs_done, winner_end, arb_lost, start_cmd} = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 retx after reset", retx_req, 0);
    check("R1 flag after reset", arb_lost_flag, 0);
    retry_limit = 2'd0;
    drive(M_ARB);
    drive(M_WIN);
    drive(M_IFS);
    idle(2);
    check("R1 idle arb_lost flag", arb_lost_flag, 0);
    check("R1 idle arb_lost retx", retx_seen, 0);
  endtask

  task automatic t_zero_limit;
    int base;
    base = retx_seen;
    retry_limit = 2'd0;
    drive(M_START);
    drive(M_ARB);
    check("R2 flag after zero-limit loss", arb_lost_flag, 1);
    drive(M_WIN);
    drive(M_IFS);
    idle(4);
    check("R10 no self retransmit", retx_seen - base, 0);
    check("R6 flag sticky", arb_lost_flag, 1);
    drive(M_CLR);
    check("R6 flag cleared by w1c", arb_lost_flag, 0);
  endtask

  task automatic t_order;
    int base;
    base = retx_seen;
    retry_limit = 2'd1;
    drive(M_START);
    drive(M_ARB);
    check("R2 flag not set with budget", arb_lost_flag, 0);
    drive(M_IFS);
    idle(2);
    check("R3 early ifs ignored", retx_seen - base, 0);
    drive(M_WIN);
    idle(3);
    check("R3 no retx before ifs", retx_seen - base, 0);
    drive(M_IFS);
    check("R4 retx due after ifs edge", retx_req, 1);
    @(negedge clk);
    check("R4 retx one cycle", retx_req, 0);
    check("R4 single pulse", retx_seen - base, 1);
    drive(M_DONE);
  endtask

  task automatic t_budget(input int n);
    int base;
    base = retx_seen;
    retry_limit = 2'(n);
    drive(M_START);
    for (int k = 0; k < n; k++) begin
      drive(M_ARB);
      drive(M_WIN);
      drive(M_IFS);
      check("R5 retx per allowed loss", retx_req, 1);
      idle(1);
    end
    drive(M_ARB);
    check("R5 flag after budget used", arb_lost_flag, 1);
    drive(M_WIN);
    drive(M_IFS);
    idle(3);
    check("R5 retransmit total", retx_seen - base, n);
    check("R10 none after exhaustion", retx_req, 0);
  endtask

  task automatic t_restart;
    int base;
    // flag is still set from the exhausted budget
    retry_limit = 2'd2;
    drive(M_START);
    check("R7 start clears flag", arb_lost_flag, 0);
    base = retx_seen;
    drive(M_ARB);
    drive(M_WIN);
    drive(M_IFS);
    idle(1);
    drive(M_ARB);
    drive(M_WIN);
    drive(M_IFS);
    idle(1);
    check("R7 fresh budget retries", retx_seen - base, 2);
    check("R7 flag clear within budget", arb_lost_flag, 0);
    drive(M_DONE);
  endtask

  task automatic t_done;
    int base;
    base = retx_seen;
    retry_limit = 2'd1;
    drive(M_START);
    drive(M_DONE);
    drive(M_ARB);
    drive(M_WIN);
    drive(M_IFS);
    idle(2);
    check("R8 idle after done flag", arb_lost_flag, 0);
    check("R8 idle after done retx", retx_seen - base, 0);
  endtask

  task automatic t_abort;
    int base;
    base = retx_seen;
    retry_limit = 2'd3;
    drive(M_START);
    drive(M_ARB);
    drive(M_WIN);
    drive(M_START);
    drive(M_IFS);
    idle(3);
    check("R9 pending retry cancelled", retx_seen - base, 0);
    drive(M_DONE);
  endtask

  task automatic t_set_wins;
    retry_limit = 2'd0;
    drive(M_START);
    drive(M_ARB | M_CLR);
    check("R6 set beats clear", arb_lost_flag, 1);
    drive(M_START | M_ARB);
    check("R7 start beats loss", arb_lost_flag, 0);
    drive(M_DONE);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_limit();
    t_order();
    t_budget(1);
    t_budget(2);
    t_budget(3);
    t_restart();
    t_done();
    t_abort();
    t_set_wins();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule